// File: doc/BRIEF.md
# Dual-Port Memory with Same-Address Collision Arbitration

This block puts a small true dual-port memory behind a collision arbiter. Two independent ports, called left and right, each present an active-low select, an active-low write strobe (high means read), an active-low output enable, an address and write data. Whenever both ports are selected on the same word, the arbiter lets one of them keep the word. It marks the other as busy and suppresses any write that the losing port attempts. The decision looks only at selects and addresses, never at the direction of the access.

The design runs on one clock and samples both ports every cycle. A port counts as first if it was already selected on that word in an earlier cycle than its rival. If both ports arrive in the same cycle, left wins. A mode pin picks one of two behaviours. In master behaviour the arbiter computes busy and drives it out. In slave behaviour the busy pins become plain write-inhibit inputs from some other arbiter, so several blocks can share one decision when the data path is widened.

Top module: `dpr_arbiter_top`

## Requirements
- R1: When either port is deselected, or the two addresses differ, both busy outputs read high (1) after the next clock edge.
- R2: The arbitration outcome does not depend on the write strobes or output enables: a collision of two reads and a collision of two writes on the same word pick the same winner.
- R3: In master mode (slave_mode = 0), if one port was already selected on a word in the previous cycle and the other port now selects that same word, the newcomer's busy output goes low after the next edge and the holder's busy output stays high.
- R4: The two busy outputs are never low in the same cycle.
- R5: When both ports start selecting the same word in the same cycle, left wins and right's busy output goes low.
- R6: In master mode, a write from the losing port of a collision leaves memory unchanged, whatever level the busy input pins carry. The winning port's write completes even when its own busy input pin is held low.
- R7: In slave mode (slave_mode = 1), both busy outputs stay high. A low busy input blocks only writes from that port, and reads from that port still return data.
- R8: In slave mode, a high busy input lets that port write normally.
- R9: A port writes only when select and write strobe are both low. Read data appears one cycle after a cycle in which select and output enable are low and the write strobe is high, with rvalid high. Any other cycle yields rvalid low.
- R10: Busy is released after the first edge at which the addresses no longer match or either port is deselected. The stored winner is cleared then too, so a later collision is arbitrated afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slave_mode | input | 1 | 1 = busy pins act as write-inhibit inputs; 0 = arbiter drives busy |
| l_ce_n | input | 1 | Left select, active low |
| l_rw_n | input | 1 | Left write strobe, low = write, high = read |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left read data, valid when l_rvalid is high |
| l_rvalid | output | 1 | Left read data valid |
| l_busy_n_i | input | 1 | Left write inhibit, active low, used in slave mode |
| l_busy_n_o | output | 1 | Left busy, active low, driven in master mode |
| r_ce_n | input | 1 | Right select, active low |
| r_rw_n | input | 1 | Right write strobe, low = write, high = read |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right read data, valid when r_rvalid is high |
| r_rvalid | output | 1 | Right read data valid |
| r_busy_n_i | input | 1 | Right write inhibit, active low, used in slave mode |
| r_busy_n_o | output | 1 | Right busy, active low, driven in master mode |

## Verification
The assertions assume that reset is held for at least one edge and that all port inputs are settled before each clock edge. They also assume slave_mode changes only while no collision is pending, and that in slave mode two writes to the same word in the same cycle never occur. The bench changes inputs only just after an edge. It toggles slave_mode only between idle cycles. The random phase runs in master mode only, over eight addresses so that collisions are frequent, and the arbiter then resolves every same-word pair.

// File: rtl/dpr_pkg.sv
// Shared types for the dual-port collision arbiter.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package dpr_pkg;

    // Which side holds a contended word.
    typedef enum logic {
        SIDE_LEFT  = 1'b0,
        SIDE_RIGHT = 1'b1
    } side_e;

    // Tie-break picks the newcomer-free side: right wins only when it alone was settled.
    function automatic side_e pick_side(input logic l_settled, input logic r_settled);
        return (r_settled && !l_settled) ? SIDE_RIGHT : SIDE_LEFT;
    endfunction

endpackage

// File: rtl/dpr_collision_arb.sv
// Same-word collision arbiter.
// Compares the two selected addresses every cycle. Picks the port that was
// settled on the word first (left on a tie), keeps that choice while the
// match lasts, and registers the busy flags one cycle later.
// Assumes: enables are active high here, and inputs settle before each edge.
module dpr_collision_arb
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_en,
    input  logic              r_en,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [ADDR_W-1:0] r_addr,
    output logic              lose_l,
    output logic              lose_r,
    output logic              busy_l_q,
    output logic              busy_r_q
);

    logic              l_en_q, r_en_q;
    logic [ADDR_W-1:0] l_addr_q, r_addr_q;
    logic              win_vld_q;
    side_e             win_q;
    logic              match, l_settled, r_settled;
    side_e             win_now;

    // Classify the present cycle: collision, and which side was already settled.
    always_comb begin
        match     = l_en && r_en && (l_addr == r_addr);
        l_settled = l_en && l_en_q && (l_addr == l_addr_q);
        r_settled = r_en && r_en_q && (r_addr == r_addr_q);
        win_now   = win_vld_q ? win_q : pick_side(l_settled, r_settled);
        lose_l    = match && (win_now == SIDE_RIGHT);
        lose_r    = match && (win_now == SIDE_LEFT);
    end

    // Remember last cycle's requests for the arrival comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_en_q   <= 1'b0;
            r_en_q   <= 1'b0;
            l_addr_q <= '0;
            r_addr_q <= '0;
        end else begin
            l_en_q   <= l_en;
            r_en_q   <= r_en;
            l_addr_q <= l_addr;
            r_addr_q <= r_addr;
        end
    end

    // Hold the winner while the match lasts, drop it the edge after.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_vld_q <= 1'b0;
            win_q     <= SIDE_LEFT;
            busy_l_q  <= 1'b0;
            busy_r_q  <= 1'b0;
        end else begin
            win_vld_q <= match;
            win_q     <= match ? win_now : SIDE_LEFT;
            busy_l_q  <= lose_l;
            busy_r_q  <= lose_r;
        end
    end

    AST_BUSY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_l_q && busy_r_q)); // R4

    AST_IDLE_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !match |=> (!busy_l_q && !busy_r_q)); // R1

    AST_FIRST_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (match && l_settled && !r_settled) |=> (busy_r_q && !busy_l_q)); // R3

    AST_TIE_TO_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !win_vld_q && !l_settled && !r_settled) |=> busy_r_q); // R5

endmodule

// File: rtl/dpr_mem_array.sv
// Behavioural two-port word array with registered reads.
// Each port writes on the edge when its write enable is high and reads the
// pre-write contents on the same edge. Contents are not reset.
// Assumes: the caller never enables both writes to one word in one cycle;
// if it does, the right port's data is the one kept.
module dpr_mem_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_we,
    input  logic              l_re,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_rvalid,
    input  logic              r_we,
    input  logic              r_re,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_rvalid
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words [DEPTH];

    // Apply the permitted writes from both ports.
    always_ff @(posedge clk) begin
        if (l_we) words[l_addr] <= l_wdata;
        if (r_we) words[r_addr] <= r_wdata;
    end

    // Register read data and its valid flag per port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_rdata  <= '0;
            r_rdata  <= '0;
            l_rvalid <= 1'b0;
            r_rvalid <= 1'b0;
        end else begin
            l_rvalid <= l_re;
            r_rvalid <= r_re;
            if (l_re) l_rdata <= words[l_addr];
            if (r_re) r_rdata <= words[r_addr];
        end
    end

endmodule

// File: rtl/dpr_arbiter_top.sv
// Dual-port memory with same-word collision arbitration.
// Master mode: the internal arbiter decides busy, drives it out, and gates
// the loser's write using its own decision, ignoring the busy input pins.
// Slave mode: busy outputs stay high and each busy input gates only that
// port's writes.
// Assumes: slave_mode changes only while no collision is pending.
module dpr_arbiter_top #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slave_mode,
    input  logic              l_ce_n,
    input  logic              l_rw_n,
    input  logic              l_oe_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_rvalid,
    input  logic              l_busy_n_i,
    output logic              l_busy_n_o,
    input  logic              r_ce_n,
    input  logic              r_rw_n,
    input  logic              r_oe_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_rvalid,
    input  logic              r_busy_n_i,
    output logic              r_busy_n_o
);

    logic l_en, r_en;
    logic lose_l, lose_r, busy_l_q, busy_r_q;
    logic inhibit_l, inhibit_r;
    logic wr_l, wr_r, rd_l, rd_r;

    // Decode port strobes and choose the write-inhibit source per mode.
    always_comb begin
        l_en      = !l_ce_n;
        r_en      = !r_ce_n;
        inhibit_l = slave_mode ? !l_busy_n_i : lose_l;
        inhibit_r = slave_mode ? !r_busy_n_i : lose_r;
        wr_l      = l_en && !l_rw_n && !inhibit_l;
        wr_r      = r_en && !r_rw_n && !inhibit_r;
        rd_l      = l_en && l_rw_n && !l_oe_n;
        rd_r      = r_en && r_rw_n && !r_oe_n;
    end

    // Busy pins are driven only in master mode.
    always_comb begin
        l_busy_n_o = slave_mode ? 1'b1 : !busy_l_q;
        r_busy_n_o = slave_mode ? 1'b1 : !busy_r_q;
    end

    dpr_collision_arb #(
        .ADDR_W (ADDR_W)
    ) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .l_en     (l_en),
        .r_en     (r_en),
        .l_addr   (l_addr),
        .r_addr   (r_addr),
        .lose_l   (lose_l),
        .lose_r   (lose_r),
        .busy_l_q (busy_l_q),
        .busy_r_q (busy_r_q)
    );

    dpr_mem_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .l_we     (wr_l),
        .l_re     (rd_l),
        .l_addr   (l_addr),
        .l_wdata  (l_wdata),
        .l_rdata  (l_rdata),
        .l_rvalid (l_rvalid),
        .r_we     (wr_r),
        .r_re     (rd_r),
        .r_addr   (r_addr),
        .r_wdata  (r_wdata),
        .r_rdata  (r_rdata),
        .r_rvalid (r_rvalid)
    );

    AST_LEFT_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_ce_n && !l_oe_n && l_rw_n) |=> l_rvalid); // R9

    AST_LEFT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !(!l_ce_n && !l_oe_n && l_rw_n) |=> !l_rvalid); // R9

endmodule

// File: tb/tb_dpr_arbiter_top.sv
// Bench: directed corner cases, then seeded random traffic in master mode
// checked against a requirement-level model kept in bench tasks.
module tb_dpr_arbiter_top;

    localparam int AW = 10;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          slave_mode = 1'b0;
    logic          l_ce_n = 1'b1, l_rw_n = 1'b1, l_oe_n = 1'b1;
    logic [AW-1:0] l_addr = '0;
    logic [DW-1:0] l_wdata = '0;
    logic [DW-1:0] l_rdata;
    logic          l_rvalid, l_busy_n_o;
    logic          l_busy_n_i = 1'b1;
    logic          r_ce_n = 1'b1, r_rw_n = 1'b1, r_oe_n = 1'b1;
    logic [AW-1:0] r_addr = '0;
    logic [DW-1:0] r_wdata = '0;
    logic [DW-1:0] r_rdata;
    logic          r_rvalid, r_busy_n_o;
    logic          r_busy_n_i = 1'b1;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dpr_arbiter_top #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
        .l_ce_n(l_ce_n), .l_rw_n(l_rw_n), .l_oe_n(l_oe_n), .l_addr(l_addr),
        .l_wdata(l_wdata), .l_rdata(l_rdata), .l_rvalid(l_rvalid),
        .l_busy_n_i(l_busy_n_i), .l_busy_n_o(l_busy_n_o),
        .r_ce_n(r_ce_n), .r_rw_n(r_rw_n), .r_oe_n(r_oe_n), .r_addr(r_addr),
        .r_wdata(r_wdata), .r_rdata(r_rdata), .r_rvalid(r_rvalid),
        .r_busy_n_i(r_busy_n_i), .r_busy_n_o(r_busy_n_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Advance one edge; inputs change and outputs are sampled 1 ns after it.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set_l(input logic ce, input logic rw, input logic oe,
                         input int a, input int d);
        l_ce_n = ce; l_rw_n = rw; l_oe_n = oe; l_addr = AW'(a); l_wdata = DW'(d);
    endtask

    task automatic set_r(input logic ce, input logic rw, input logic oe,
                         input int a, input int d);
        r_ce_n = ce; r_rw_n = rw; r_oe_n = oe; r_addr = AW'(a); r_wdata = DW'(d);
    endtask

    task automatic idle();
        set_l(1, 1, 1, 0, 0);
        set_r(1, 1, 1, 0, 0);
    endtask

    // Reference model state for the random phase.
    logic [DW-1:0] ref_mem [8];
    bit            m_len, m_ren, m_wv, m_wr;
    logic [AW-1:0] m_la, m_ra;

    task automatic random_phase(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            bit lce, rce, lrw, rrw, loe, roe;
            bit match, lset, rset, cw, losel, loser, elv, erv;
            logic [DW-1:0] eld, erd;
            int la, ra;
            lce = ($urandom % 4) != 0; rce = ($urandom % 4) != 0;
            lrw = $urandom % 2; rrw = $urandom % 2;
            loe = $urandom % 2; roe = $urandom % 2;
            la = $urandom % 8;  ra = $urandom % 8;
            set_l(!lce, lrw, loe, la, $urandom % 256);
            set_r(!rce, rrw, roe, ra, $urandom % 256);
            l_busy_n_i = $urandom % 2;
            r_busy_n_i = $urandom % 2;
            match = lce && rce && (la == ra);
            lset  = lce && m_len && (AW'(la) == m_la);
            rset  = rce && m_ren && (AW'(ra) == m_ra);
            cw    = m_wv ? m_wr : (rset && !lset);
            losel = match && cw;
            loser = match && !cw;
            elv = lce && !loe && lrw;
            erv = rce && !roe && rrw;
            eld = ref_mem[la];
            erd = ref_mem[ra];
            if (lce && !lrw && !losel) ref_mem[la] = l_wdata;
            if (rce && !rrw && !loser) ref_mem[ra] = r_wdata;
            m_len = lce; m_ren = rce; m_la = AW'(la); m_ra = AW'(ra);
            m_wv = match; m_wr = match ? cw : 1'b0;
            tick();
            chk("R3 random left busy", l_busy_n_o, !losel);
            chk("R3 random right busy", r_busy_n_o, !loser);
            chk("R4 busy exclusive", {31'b0, !l_busy_n_o && !r_busy_n_o}, 0);
            chk("R9 random left rvalid", l_rvalid, elv);
            chk("R9 random right rvalid", r_rvalid, erv);
            if (elv) chk("R6 random left rdata", l_rdata, eld);
            if (erv) chk("R6 random right rdata", r_rdata, erd);
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        idle();
        repeat (3) tick();
        rst_n = 1'b1;
        chk("R1 reset left busy", l_busy_n_o, 1);
        chk("R1 reset right busy", r_busy_n_o, 1);
        chk("R9 reset rvalid", l_rvalid, 0);

        // R9: write, read back, suppressed write, read without output enable.
        set_l(0, 0, 1, 5, 'hA5); tick();
        set_l(0, 1, 0, 5, 0); tick();
        chk("R9 read valid", l_rvalid, 1);
        chk("R9 read data", l_rdata, 'hA5);
        set_l(1, 0, 1, 5, 'h3C); tick();
        set_l(0, 1, 0, 5, 0); tick();
        chk("R9 deselected write ignored", l_rdata, 'hA5);
        set_l(0, 1, 1, 5, 0); tick();
        chk("R9 no read without oe", l_rvalid, 0);

        // R1: differing addresses, and same address with left deselected.
        set_l(0, 1, 0, 6, 0); set_r(0, 1, 0, 7, 0); tick();
        chk("R1 differ left", l_busy_n_o, 1);
        chk("R1 differ right", r_busy_n_o, 1);
        set_l(1, 1, 0, 7, 0); tick();
        chk("R1 deselected right", r_busy_n_o, 1);
        idle(); tick();

        // R3/R6: left settled first, right write on the same word blocked.
        set_l(0, 0, 1, 9, 'h11); tick();
        set_l(0, 1, 0, 9, 0); set_r(0, 0, 1, 9, 'h77); tick();
        chk("R3 newcomer right busy", r_busy_n_o, 0);
        chk("R3 holder left free", l_busy_n_o, 1);
        set_r(0, 1, 0, 10, 0); tick();
        chk("R10 mismatch releases right", r_busy_n_o, 1);
        idle(); tick();
        set_l(0, 1, 0, 9, 0); tick();
        chk("R6 loser write blocked", l_rdata, 'h11);
        idle(); tick();

        // R5/R2: tie of two reads, then tie of two writes.
        set_l(0, 1, 0, 12, 0); set_r(0, 1, 0, 12, 0); tick();
        chk("R5 tie reads right busy", r_busy_n_o, 0);
        chk("R5 tie reads left free", l_busy_n_o, 1);
        idle(); tick();
        set_l(0, 0, 1, 12, 'h21); set_r(0, 0, 1, 12, 'h43); tick();
        chk("R2 tie writes right busy", r_busy_n_o, 0);
        chk("R2 tie writes left free", l_busy_n_o, 1);
        idle(); tick();
        set_l(0, 1, 0, 12, 0); tick();
        chk("R6 tie keeps left data", l_rdata, 'h21);
        idle(); tick();

        // R3: right settled first, left write blocked.
        set_r(0, 0, 1, 20, 'h5A); tick();
        set_r(0, 1, 0, 20, 0); set_l(0, 0, 1, 20, 'h99); tick();
        chk("R3 newcomer left busy", l_busy_n_o, 0);
        chk("R3 holder right free", r_busy_n_o, 1);
        tick();
        chk("R3 left still busy", l_busy_n_o, 0);
        idle(); tick();
        chk("R10 release left", l_busy_n_o, 1);
        chk("R10 release right", r_busy_n_o, 1);
        // R10: winner cleared, so left now settled first wins.
        set_l(0, 1, 0, 20, 0); tick();
        chk("R6 left write was blocked", l_rdata, 'h5A);
        set_r(0, 1, 0, 20, 0); tick();
        chk("R10 fresh arbitration right busy", r_busy_n_o, 0);
        chk("R10 fresh arbitration left free", l_busy_n_o, 1);
        idle(); tick();

        // R6: winner writes even with its own busy input low (master mode).
        l_busy_n_i = 0; r_busy_n_i = 0;
        set_l(0, 0, 1, 30, 'h3C); set_r(0, 1, 0, 30, 0); tick();
        idle(); tick();
        set_l(0, 1, 0, 30, 0); tick();
        chk("R6 master ignores busy pin", l_rdata, 'h3C);
        idle(); l_busy_n_i = 1; r_busy_n_i = 1; tick();

        // R7/R8: slave mode.
        slave_mode = 1; tick();
        set_r(0, 0, 1, 40, 'h66); tick();
        set_r(0, 1, 0, 40, 0); tick();
        chk("R8 slave write with busy high", r_rdata, 'h66);
        r_busy_n_i = 0;
        set_r(0, 0, 1, 40, 'hEE); tick();
        set_r(0, 1, 0, 40, 0); tick();
        chk("R7 slave inhibited read valid", r_rvalid, 1);
        chk("R7 slave inhibited write blocked", r_rdata, 'h66);
        set_l(0, 0, 1, 41, 'h12); set_r(0, 1, 0, 41, 0); tick();
        chk("R7 slave outputs high left", l_busy_n_o, 1);
        chk("R7 slave outputs high right", r_busy_n_o, 1);
        set_l(0, 1, 0, 41, 0); tick();
        chk("R7 other port still writes", l_rdata, 'h12);
        idle(); r_busy_n_i = 1; tick();
        slave_mode = 0; tick();

        // Preload the random window, then random master-mode traffic.
        for (int a = 0; a < 8; a++) begin
            ref_mem[a] = DW'($urandom % 256);
            set_l(0, 0, 1, a, ref_mem[a]);
            tick();
        end
        idle(); tick();
        m_len = 0; m_ren = 0; m_wv = 0; m_wr = 0; m_la = '0; m_ra = '0;
        random_phase(3000);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule